// File: doc/BRIEF.md
# Multi-Row Open Page Tracker

This block records which DRAM pages a memory controller currently holds open across a set of device rows (eight by default). Each row has several banks, and each bank can hold one open page. The controller presents a lookup made of a row index, a bank and a byte address within that row. The block answers at once with one of three outcomes:

- a page hit, so the column command can go out directly;
- a miss in a bank that already holds a different page, so the bank needs a precharge and then an activate;
- an idle bank, so an activate alone is enough.

Each row has its own configuration, and that configuration decides where its page boundary falls. The configuration sets the column-address width, which selects one of three page sizes. It also says whether the row is built from devices with the full bank count or with half of it. Activate and precharge commands update the state of exactly one bank of one row. A separate clear input closes every page in the block in one cycle. The block does not time commands and does not schedule refresh.

Top module: `open_page_tracker`

## Requirements
- R1: After reset every bank of every row reads as idle (lk_res = 2'b00), whatever the lookup address.
- R2: lk_res is combinational from the stored state and the lookup inputs. It is 2'b00 (idle) when the addressed bank holds no open page. It is 2'b01 (hit) when that bank holds the requested page number. It is 2'b10 (miss) when that bank holds a different page number. The code 2'b11 never appears.
- R3: cmd_op = 2'b01 (activate) marks the bank given by cmd_row/cmd_bank as open and stores the page number of cmd_addr. A lookup sees the change from the cycle after the command.
- R4: cmd_op = 2'b10 (precharge) closes only the addressed bank of the addressed row. Every other bank keeps its state.
- R5: When pre_all is high, every bank of every row is idle in the next cycle. pre_all takes priority over any cmd_op given in the same cycle.
- R6: The page number is the byte address shifted right by 12 + s, where s is the row's 2-bit field in cfg_col_sel (bits 2r+1:2r). s = 0, 1 and 2 mean 9, 10 and 11 column lines, which give 4 KB, 8 KB and 16 KB pages. s = 3 behaves like 2. Address bits below the page boundary never affect the outcome.
- R7: When cfg_full_bank[r] is 0, row r uses half the banks and ignores the top bank bit: bank 2 aliases bank 0 and bank 3 aliases bank 1, in both commands and lookups.
- R8: Rows are independent. All rows, and all banks of a full-bank row, can hold open pages at the same time. A command changes state in the row named by cmd_row only.
- R9: cmd_op = 2'b00 and the reserved code 2'b11 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_col_sel | input | 2*ROWS | Per-row column-width select, 2 bits per row |
| cfg_full_bank | input | ROWS | Per-row flag: 1 = all banks used, 0 = half |
| cmd_op | input | 2 | 00 none, 01 activate, 10 precharge, 11 reserved |
| cmd_row | input | $clog2(ROWS) | Row that the command addresses |
| cmd_bank | input | $clog2(BANKS) | Bank that the command addresses |
| cmd_addr | input | ADDR_W | Byte address within the row, for activate |
| pre_all | input | 1 | Close every page in every row |
| lk_row | input | $clog2(ROWS) | Lookup row |
| lk_bank | input | $clog2(BANKS) | Lookup bank |
| lk_addr | input | ADDR_W | Lookup byte address within the row |
| lk_res | output | 2 | Outcome: 00 idle, 01 hit, 10 miss |

## Verification
The assertions run on every cycle. They check that an activate leaves its bank open with the commanded page number stored. They also check that a precharge closes its bank, that pre_all empties every row, and that a half-bank activate leaves the upper banks untouched. Further checks are that at most one row takes a command per cycle and that the unused outcome code never appears. Only the bench's scenarios can show the address-split behaviour under each column setting, and the bank aliasing as seen through lookups. The same holds for the independence of rows and for the ignored command codes, because each of these needs a model of which page every bank should hold.

// File: rtl/opt_pkg.sv
package opt_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_ACT = 2'b01,
        OP_PRE = 2'b10,
        OP_RSV = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        RES_IDLE = 2'b00,
        RES_HIT  = 2'b01,
        RES_MISS = 2'b10
    } page_res_e;

    // byte offset bits of the smallest page (9 column lines x 8 bytes)
    localparam int unsigned BASE_SHIFT = 12;
endpackage

// File: rtl/page_split.sv
module page_split
    import opt_pkg::*;
#(
    parameter int unsigned ADDR_W = 27,
    parameter int unsigned PAGE_W = ADDR_W - BASE_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        sel,
    output logic [PAGE_W-1:0] page
);
    logic [1:0]        extra;
    logic [ADDR_W-1:0] shifted;

    always_comb begin
        extra   = (sel == 2'd3) ? 2'd2 : sel;
        shifted = addr >> (BASE_SHIFT + 32'(extra));
        page    = shifted[PAGE_W-1:0];
    end
endmodule

// File: rtl/row_tracker.sv
module row_tracker
    import opt_pkg::*;
#(
    parameter int unsigned BANKS  = 4,
    parameter int unsigned PAGE_W = 15,
    localparam int unsigned BK_W  = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              act_en,
    input  logic              pre_en,
    input  logic              full_bank,
    input  logic [BK_W-1:0]   cmd_bank,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic [BK_W-1:0]   lk_bank,
    input  logic [PAGE_W-1:0] lk_page,
    output logic [1:0]        lk_res
);
    typedef struct packed {
        logic [BANKS-1:0]             vld;
        logic [BANKS-1:0][PAGE_W-1:0] tag;
    } row_state_t;

    row_state_t st_d, st_q;
    logic [BK_W-1:0] cb_eff, lb_eff;

    always_comb begin
        cb_eff = cmd_bank;
        lb_eff = lk_bank;
        if (!full_bank) begin
            cb_eff[BK_W-1] = 1'b0;
            lb_eff[BK_W-1] = 1'b0;
        end

        st_d = st_q;
        if (clr_all) begin
            st_d.vld = '0;
        end else if (act_en) begin
            st_d.vld[cb_eff] = 1'b1;
            st_d.tag[cb_eff] = cmd_page;
        end else if (pre_en) begin
            st_d.vld[cb_eff] = 1'b0;
        end

        if (!st_q.vld[lb_eff])
            lk_res = RES_IDLE;
        else if (st_q.tag[lb_eff] == lk_page)
            lk_res = RES_HIT;
        else
            lk_res = RES_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        act_en && !clr_all |=> st_q.vld[$past(cb_eff)] &&
                               st_q.tag[$past(cb_eff)] == $past(cmd_page));

    a_r4_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en && !act_en && !clr_all |=> !st_q.vld[$past(cb_eff)]);

    a_r5_row_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> st_q.vld == '0);

    a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en || pre_en) && !clr_all && !full_bank |=>
            $stable(st_q.vld[BANKS-1:BANKS/2]));
endmodule

// File: rtl/open_page_tracker.sv
module open_page_tracker
    import opt_pkg::*;
#(
    parameter int unsigned ROWS   = 8,
    parameter int unsigned BANKS  = 4,
    parameter int unsigned ADDR_W = 27,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned BK_W   = $clog2(BANKS),
    localparam int unsigned PAGE_W = ADDR_W - BASE_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*ROWS-1:0]   cfg_col_sel,
    input  logic [ROWS-1:0]     cfg_full_bank,
    input  logic [1:0]          cmd_op,
    input  logic [ROW_W-1:0]    cmd_row,
    input  logic [BK_W-1:0]     cmd_bank,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic                pre_all,
    input  logic [ROW_W-1:0]    lk_row,
    input  logic [BK_W-1:0]     lk_bank,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic [1:0]          lk_res
);
    logic [PAGE_W-1:0] cmd_page, lk_page;
    logic [1:0]        cmd_sel, lk_sel;
    logic [ROWS-1:0]   act_vec, pre_vec;
    logic [1:0]        row_res [ROWS];

    always_comb begin
        cmd_sel = cfg_col_sel[2*cmd_row +: 2];
        lk_sel  = cfg_col_sel[2*lk_row +: 2];
    end

    page_split #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cmd_split (
        .addr(cmd_addr), .sel(cmd_sel), .page(cmd_page)
    );

    page_split #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_lk_split (
        .addr(lk_addr), .sel(lk_sel), .page(lk_page)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_comb begin
            act_vec[r] = (cmd_op == OP_ACT) && (cmd_row == ROW_W'(r));
            pre_vec[r] = (cmd_op == OP_PRE) && (cmd_row == ROW_W'(r));
        end

        row_tracker #(.BANKS(BANKS), .PAGE_W(PAGE_W)) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_all   (pre_all),
            .act_en    (act_vec[r]),
            .pre_en    (pre_vec[r]),
            .full_bank (cfg_full_bank[r]),
            .cmd_bank  (cmd_bank),
            .cmd_page  (cmd_page),
            .lk_bank   (lk_bank),
            .lk_page   (lk_page),
            .lk_res    (row_res[r])
        );
    end

    assign lk_res = row_res[lk_row];

    a_r8_one_row: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_vec | pre_vec));

    a_r2_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_res != 2'b11);

    a_r5_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |=> lk_res == RES_IDLE);
endmodule

// File: tb/tb_open_page_tracker.sv
`timescale 1ns/1ps
module tb_open_page_tracker;
    localparam int ROWS = 8, BANKS = 4, AW = 27;

    logic clk = 0, rst_n = 0;
    logic [2*ROWS-1:0] cfg_col_sel;
    logic [ROWS-1:0]   cfg_full_bank;
    logic [1:0]  cmd_op = 0;
    logic [2:0]  cmd_row = 0, lk_row = 0;
    logic [1:0]  cmd_bank = 0, lk_bank = 0;
    logic [AW-1:0] cmd_addr = 0, lk_addr = 0;
    logic pre_all = 0;
    logic [1:0] lk_res;

    int n_run = 0, n_fail = 0;
    int sel [ROWS];
    bit mv [ROWS][BANKS];
    logic [AW-1:0] mt [ROWS][BANKS];

    always #4 clk = ~clk;

    open_page_tracker dut (.*);

    function automatic logic [AW-1:0] pg(int r, logic [AW-1:0] a);
        int s = (sel[r] == 3) ? 2 : sel[r];
        return a >> (12 + s);
    endfunction

    function automatic int fold(int r, int b);
        return cfg_full_bank[r] ? b : (b % 2);
    endfunction

    function automatic logic [AW-1:0] addr_of(int r, int b);
        return AW'(((r * 4 + b + 1) << 14) | 'h5a7);
    endfunction

    task automatic check(int r, int b, logic [AW-1:0] a, string req);
        int fb = fold(r, b);
        logic [1:0] exp;
        lk_row = 3'(r); lk_bank = 2'(b); lk_addr = a;
        #1;
        exp = !mv[r][fb] ? 2'b00 : (mt[r][fb] == pg(r, a) ? 2'b01 : 2'b10);
        n_run++;
        if (lk_res !== exp) begin
            n_fail++;
            $display("FAIL %s row %0d bank %0d addr %h: got %b expected %b",
                     req, r, b, a, lk_res, exp);
        end
    endtask

    task automatic cmd(logic [1:0] op, int r, int b, logic [AW-1:0] a, bit pa);
        @(negedge clk);
        cmd_op = op; cmd_row = 3'(r); cmd_bank = 2'(b); cmd_addr = a; pre_all = pa;
        @(negedge clk);
        cmd_op = 0; pre_all = 0;
        if (pa) begin
            foreach (mv[i, j]) mv[i][j] = 0;
        end else if (op == 2'b01) begin
            mv[r][fold(r, b)] = 1; mt[r][fold(r, b)] = pg(r, a);
        end else if (op == 2'b10) begin
            mv[r][fold(r, b)] = 0;
        end
    endtask

    task automatic sweep(string req);
        for (int r = 0; r < ROWS; r++)
            for (int b = 0; b < BANKS; b++)
                check(r, b, addr_of(r, b), req);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            sel[r] = (r == 7) ? 3 : r % 3;
            cfg_col_sel[2*r +: 2] = 2'(sel[r]);
            cfg_full_bank[r] = (r % 2 == 0);
            for (int b = 0; b < BANKS; b++) begin mv[r][b] = 0; mt[r][b] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: idle everywhere after reset
        sweep("R1");
        check(0, 0, 0, "R1");

        // R3/R8: open a page in every bank of every row
        for (int r = 0; r < ROWS; r++)
            for (int b = 0; b < BANKS; b++)
                cmd(2'b01, r, b, addr_of(r, b), 0);
        sweep("R3 R8");

        // R2: miss on a different page of an open bank
        for (int r = 0; r < ROWS; r++)
            check(r, 0, addr_of(r, 0) ^ AW'(1 << 20), "R2");

        // R6: offsets below the page boundary are ignored, bits 12/13 depend on sel
        for (int r = 0; r < ROWS; r++) begin
            check(r, 1, addr_of(r, 1) ^ AW'('hfff), "R6");
            check(r, 1, addr_of(r, 1) ^ AW'(1 << 12), "R6");
            check(r, 1, addr_of(r, 1) ^ AW'(1 << 13), "R6");
        end

        // R7: half-bank rows alias banks 2/3 onto 0/1
        cmd(2'b01, 1, 2, addr_of(1, 0), 0);
        check(1, 0, addr_of(1, 0), "R7");
        check(1, 2, addr_of(1, 0), "R7");
        check(1, 3, addr_of(1, 3), "R7");

        // R4: precharge closes one bank only
        cmd(2'b10, 0, 1, 0, 0);
        cmd(2'b10, 3, 3, 0, 0);
        sweep("R4");

        // R9: no-op and reserved code leave state alone
        cmd(2'b00, 2, 0, 0, 0);
        cmd(2'b11, 2, 1, 0, 0);
        cmd(2'b11, 4, 0, AW'(1 << 22), 0);
        sweep("R9");

        // R5: pre_all wins over a simultaneous activate
        cmd(2'b01, 5, 0, addr_of(5, 0), 1);
        sweep("R5");
        check(5, 0, addr_of(5, 0), "R5");

        // R3 again after clearing, then R5 alone
        cmd(2'b01, 6, 2, addr_of(6, 2), 0);
        check(6, 2, addr_of(6, 2), "R3");
        cmd(2'b00, 0, 0, 0, 1);
        sweep("R5");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule